// File: doc/BRIEF.md
# Three-Wire Audio Control Bus Slave

This block is the digital front end of a stereo audio control device. A host drives three lines: a bus clock, an identity line and a data line that the block can also pull low. Each command is one address byte and one function byte. The identity level decides which byte is being shifted in. The address picks the device and one of eight functions. A separate low pulse on identity then commits the function byte into that function's register.

The block decodes the committed bytes into ready-to-use control values: source selection and mute, loudness, stereo widening, bass and treble step indices, a left and a right attenuation index, and the channel routing mode. Volume and tone codes beyond their top step saturate there. One function address turns the data phase into a read. During that read the block pulls the data line low to return the levels of two active-low status inputs.

All bus lines and status inputs are oversampled by the fast system clock through two-flop synchronizers. Edges are detected in the system clock domain.

Top module: `ctl3w_slave`

## Requirements
- R1: A bit is taken from the data line on each rising edge of the bus clock, MSB first. The address is the last 8 bits shifted in while identity is low. The function byte is the last 8 bits shifted in after identity rises. A phase may carry more than 8 bits.
- R2: Registers change only when a low pulse on identity lasts at least ID_MIN_CYC system clocks, with no bus clock edge during it, and follows a data phase of at least 8 bits. A missing pulse or a shorter pulse leaves every output unchanged.
- R3: Only addresses 0x40 to 0x47 are accepted. Bits [2:0] select the function: 0 source, 1 loudness/widening, 2 bass, 3 treble, 4 left volume, 5 right volume, 6 mode, 7 read. Any other address updates nothing and never pulls the data line.
- R4: Source function, bits [1:0]: 00 gives src_o=0 and mute_o=0; 01 gives src_o=1 and mute_o=0; 11 sets mute_o=1 and keeps src_o; 10 changes nothing.
- R5: The loudness/widening function sets loud_o from bit 0 and wide_o from bit 1.
- R6: Bass and treble take bits [3:0] as a step index, where 0 is the deepest cut and 6 is flat. Codes 12 to 15 all give 12. Bits [7:4] are ignored.
- R7: Each volume function takes bits [5:0] as an attenuation index in 2 dB steps. Codes 40 to 63 all give 40. Bits [7:6] are ignored.
- R8: Mode function, bits [2:0]: 100 gives left mono (mode_o=1), 101 gives stereo (mode_o=0), 11x gives right mono (mode_o=2), and 0xx changes nothing.
- R9: For the read function, bit 1 of the 8-bit data phase carries stat_n_i[1] and bit 0 carries stat_n_i[0]. Bit 1 is the 7th bit sent and bit 0 the 8th. A 0 is sent by pulling the line low, and all other bits are released. The levels are captured when the address is accepted. The drive changes after bus clock falling edges. Committing a read changes no register.
- R10: After reset both volumes are 40, bass and treble are 6, mute_o=1, src_o=0, loud_o=wide_o=0, mode_o is stereo and the data line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| bus_clk_i | input | 1 | Bus clock from the host |
| bus_id_i | input | 1 | Identity line: low for the address phase, high for the data phase, low pulse to commit |
| bus_dat_i | input | 1 | Data line as seen on the wire |
| stat_n_i | input | 2 | Active-low status levels returned by the read function |
| bus_dat_low_o | output | 1 | Open-drain pull-down enable for the data line |
| src_o | output | 1 | Selected source, 0 or 1 |
| mute_o | output | 1 | Mute active |
| loud_o | output | 1 | Loudness compensation on |
| wide_o | output | 1 | Stereo widening on |
| bass_o | output | 4 | Bass step index, 0 to 12 |
| treble_o | output | 4 | Treble step index, 0 to 12 |
| vol_l_o | output | 6 | Left attenuation index, 0 to 40 |
| vol_r_o | output | 6 | Right attenuation index, 0 to 40 |
| mode_o | output | 2 | Routing: 0 stereo, 1 left mono, 2 right mono |

## Verification
The bench sends frames that stop before the commit pulse, or end it too early. A design that commits on the identity rise alone would change the volume in these cases. It also sends addresses that differ from the device range in the upper bits, which a loose compare would accept. Overlong phases check that only the last 8 bits count, and codes above the top step check saturation, which a plain copy of the code would pass through. In the read tests the status inputs change after the address is accepted. A design that samples them late, puts the two bits in the wrong order or drives on the wrong edge returns the wrong byte.

// File: rtl/ctl3w_pkg.sv
package ctl3w_pkg;

    localparam int BYTE_W    = 8;
    localparam int FN_W      = 3;
    localparam int DEV_W     = BYTE_W - FN_W;
    localparam logic [DEV_W-1:0] DEV_ID = 5'b01000;
    localparam int NSTAT     = 2;
    localparam int TONE_W    = 4;
    localparam int TONE_MAX  = 12;
    localparam int TONE_FLAT = 6;
    localparam int VOL_W     = 6;
    localparam int VOL_MAX   = 40;
    localparam int NB_W      = $clog2(BYTE_W + 1);

    typedef enum logic [FN_W-1:0] {
        FN_SRC  = 3'd0,
        FN_LOUD = 3'd1,
        FN_BASS = 3'd2,
        FN_TREB = 3'd3,
        FN_VOLL = 3'd4,
        FN_VOLR = 3'd5,
        FN_MODE = 3'd6,
        FN_READ = 3'd7
    } fn_e;

    typedef enum logic [1:0] {
        MD_STEREO = 2'd0,
        MD_LMONO  = 2'd1,
        MD_RMONO  = 2'd2
    } mode_e;

    typedef struct packed {
        logic              src;
        logic              mute;
        logic              loud;
        logic              wide;
        logic [TONE_W-1:0] bass;
        logic [TONE_W-1:0] treble;
        logic [VOL_W-1:0]  vol_l;
        logic [VOL_W-1:0]  vol_r;
        mode_e             mode;
    } ctl_t;

    typedef struct packed {
        logic              stb;
        fn_e               fn;
        logic [BYTE_W-1:0] dat;
    } wr_t;

    function automatic logic [TONE_W-1:0] sat_tone(input logic [TONE_W-1:0] c);
        return (c > TONE_W'(TONE_MAX)) ? TONE_W'(TONE_MAX) : c;
    endfunction

    function automatic logic [VOL_W-1:0] sat_vol(input logic [VOL_W-1:0] c);
        return (c > VOL_W'(VOL_MAX)) ? VOL_W'(VOL_MAX) : c;
    endfunction

    function automatic ctl_t ctl_reset();
        ctl_t r;
        r.src    = 1'b0;
        r.mute   = 1'b1;
        r.loud   = 1'b0;
        r.wide   = 1'b0;
        r.bass   = TONE_W'(TONE_FLAT);
        r.treble = TONE_W'(TONE_FLAT);
        r.vol_l  = VOL_W'(VOL_MAX);
        r.vol_r  = VOL_W'(VOL_MAX);
        r.mode   = MD_STEREO;
        return r;
    endfunction

endpackage

// File: rtl/ctl3w_sync.sv
module ctl3w_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    logic [STAGES-1:0][N-1:0] pipe;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) pipe[0] <= '1;
                else     pipe[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) pipe[s] <= '1;
                else     pipe[s] <= pipe[s-1];
            end
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/ctl3w_frame.sv
module ctl3w_frame
    import ctl3w_pkg::*;
#(
    parameter int ID_MIN_CYC = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bclk_s,
    input  logic             id_s,
    input  logic             dat_s,
    input  logic [NSTAT-1:0] stat_n_s,
    output wr_t              wr_o,
    output logic             pull_o,
    output logic             rd_act_o
);
    localparam int WC_W = $clog2(ID_MIN_CYC + 1);

    typedef enum logic [1:0] {S_IDLE, S_ADDR, S_DATA, S_END} st_e;

    st_e               st;
    logic              clk_q;
    logic [BYTE_W-1:0] shreg;
    logic [NB_W-1:0]   nbits;
    fn_e               fn_q;
    logic [NSTAT-1:0]  stat_q;
    logic              data_ok;
    logic [WC_W-1:0]   wcnt;
    logic              pull;

    logic              rise, fall, drv;
    logic [BYTE_W-1:0] shin;
    logic [NB_W-1:0]   nbits_inc;

    assign rise      = bclk_s & ~clk_q;
    assign fall      = ~bclk_s & clk_q;
    assign shin      = {shreg[BYTE_W-2:0], dat_s};
    assign nbits_inc = (nbits == NB_W'(BYTE_W)) ? nbits : nbits + 1'b1;

    // status bit k travels at bit position k of the MSB-first data byte
    always_comb begin
        drv = 1'b0;
        for (int k = 0; k < NSTAT; k++) begin
            if (nbits == NB_W'(BYTE_W - 1 - k)) drv = ~stat_q[k];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= S_IDLE;
            clk_q   <= 1'b1;
            shreg   <= '0;
            nbits   <= '0;
            fn_q    <= FN_SRC;
            stat_q  <= '1;
            data_ok <= 1'b0;
            wcnt    <= '0;
            pull    <= 1'b0;
            wr_o    <= '0;
        end else begin
            clk_q    <= bclk_s;
            wr_o.stb <= 1'b0;
            case (st)
                S_IDLE: begin
                    if (!id_s) begin
                        st    <= S_ADDR;
                        nbits <= '0;
                    end
                end
                S_ADDR: begin
                    if (rise) begin
                        shreg <= shin;
                        nbits <= nbits_inc;
                    end
                    if (id_s) begin
                        if (nbits == NB_W'(BYTE_W) &&
                            shreg[BYTE_W-1:FN_W] == DEV_ID) begin
                            st     <= S_DATA;
                            fn_q   <= fn_e'(shreg[FN_W-1:0]);
                            stat_q <= stat_n_s;
                            nbits  <= '0;
                        end else begin
                            st <= S_IDLE;
                        end
                    end
                end
                S_DATA: begin
                    if (rise) begin
                        shreg <= shin;
                        nbits <= nbits_inc;
                    end
                    if (fall) pull <= (fn_q == FN_READ) && drv;
                    if (!id_s) begin
                        st      <= S_END;
                        wcnt    <= '0;
                        pull    <= 1'b0;
                        data_ok <= (nbits == NB_W'(BYTE_W));
                    end
                end
                S_END: begin
                    if (wcnt != WC_W'(ID_MIN_CYC)) wcnt <= wcnt + 1'b1;
                    if (rise) begin
                        st    <= S_ADDR;
                        shreg <= shin;
                        nbits <= NB_W'(1);
                    end else if (id_s) begin
                        st <= S_IDLE;
                        if (data_ok && wcnt == WC_W'(ID_MIN_CYC)) begin
                            wr_o.stb <= 1'b1;
                            wr_o.fn  <= fn_q;
                            wr_o.dat <= shreg;
                        end
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    assign pull_o   = pull;
    assign rd_act_o = (st == S_DATA) && (fn_q == FN_READ);
endmodule

// File: rtl/ctl3w_regs.sv
module ctl3w_regs
    import ctl3w_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  wr_t  wr_i,
    output ctl_t st_o
);
    ctl_t st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ctl_reset();
        end else if (wr_i.stb) begin
            case (wr_i.fn)
                FN_SRC: begin
                    case (wr_i.dat[1:0])
                        2'b00: begin st.src <= 1'b0; st.mute <= 1'b0; end
                        2'b01: begin st.src <= 1'b1; st.mute <= 1'b0; end
                        2'b11: st.mute <= 1'b1;
                        default: ;
                    endcase
                end
                FN_LOUD: begin
                    st.loud <= wr_i.dat[0];
                    st.wide <= wr_i.dat[1];
                end
                FN_BASS: st.bass   <= sat_tone(wr_i.dat[TONE_W-1:0]);
                FN_TREB: st.treble <= sat_tone(wr_i.dat[TONE_W-1:0]);
                FN_VOLL: st.vol_l  <= sat_vol(wr_i.dat[VOL_W-1:0]);
                FN_VOLR: st.vol_r  <= sat_vol(wr_i.dat[VOL_W-1:0]);
                FN_MODE: begin
                    if (wr_i.dat[2]) begin
                        if (wr_i.dat[1])      st.mode <= MD_RMONO;
                        else if (wr_i.dat[0]) st.mode <= MD_STEREO;
                        else                  st.mode <= MD_LMONO;
                    end
                end
                default: ;
            endcase
        end
    end

    assign st_o = st;
endmodule

// File: rtl/ctl3w_slave.sv
module ctl3w_slave
    import ctl3w_pkg::*;
#(
    parameter int ID_MIN_CYC = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_clk_i,
    input  logic              bus_id_i,
    input  logic              bus_dat_i,
    input  logic [NSTAT-1:0]  stat_n_i,
    output logic              bus_dat_low_o,
    output logic              src_o,
    output logic              mute_o,
    output logic              loud_o,
    output logic              wide_o,
    output logic [TONE_W-1:0] bass_o,
    output logic [TONE_W-1:0] treble_o,
    output logic [VOL_W-1:0]  vol_l_o,
    output logic [VOL_W-1:0]  vol_r_o,
    output logic [1:0]        mode_o
);
    localparam int NSYNC = 3 + NSTAT;

    logic [NSYNC-1:0] sync_q;
    wr_t              wr;
    ctl_t             st;
    logic             rd_act;

    ctl3w_sync #(.N(NSYNC), .STAGES(2)) i_sync (
        .clk (clk),
        .rst (rst),
        .d   ({stat_n_i, bus_clk_i, bus_id_i, bus_dat_i}),
        .q   (sync_q)
    );

    ctl3w_frame #(.ID_MIN_CYC(ID_MIN_CYC)) i_frame (
        .clk      (clk),
        .rst      (rst),
        .bclk_s   (sync_q[2]),
        .id_s     (sync_q[1]),
        .dat_s    (sync_q[0]),
        .stat_n_s (sync_q[NSYNC-1:3]),
        .wr_o     (wr),
        .pull_o   (bus_dat_low_o),
        .rd_act_o (rd_act)
    );

    ctl3w_regs i_regs (
        .clk  (clk),
        .rst  (rst),
        .wr_i (wr),
        .st_o (st)
    );

    assign src_o    = st.src;
    assign mute_o   = st.mute;
    assign loud_o   = st.loud;
    assign wide_o   = st.wide;
    assign bass_o   = st.bass;
    assign treble_o = st.treble;
    assign vol_l_o  = st.vol_l;
    assign vol_r_o  = st.vol_r;
    assign mode_o   = st.mode;
endmodule

// File: rtl/ctl3w_slave_chk.sv
module ctl3w_slave_chk
    import ctl3w_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_stb,
    input fn_e               wr_fn,
    input logic [BYTE_W-1:0] wr_dat,
    input ctl_t              st,
    input logic              pull,
    input logic              rd_act
);
    AST_HOLD_WITHOUT_COMMIT: assert property (@(posedge clk) disable iff (rst)
        !wr_stb |=> (st == $past(st))); // R2

    AST_TONE_SATURATED: assert property (@(posedge clk) disable iff (rst)
        (st.bass <= TONE_W'(TONE_MAX)) && (st.treble <= TONE_W'(TONE_MAX))); // R6

    AST_VOL_SATURATED: assert property (@(posedge clk) disable iff (rst)
        (st.vol_l <= VOL_W'(VOL_MAX)) && (st.vol_r <= VOL_W'(VOL_MAX))); // R7

    AST_PULL_ONLY_READ: assert property (@(posedge clk) disable iff (rst)
        pull |-> rd_act); // R9

    AST_SRC_NOFUNC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && wr_fn == FN_SRC && wr_dat[1:0] == 2'b10)
            |=> $stable({st.src, st.mute})); // R4

    AST_READ_NO_UPDATE: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && wr_fn == FN_READ) |=> $stable(st)); // R9

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (st.vol_l == VOL_W'(VOL_MAX) && st.vol_r == VOL_W'(VOL_MAX) &&
                 st.mute && st.bass == TONE_W'(TONE_FLAT) && !st.loud &&
                 !st.wide && !pull)); // R10
endmodule

bind ctl3w_slave ctl3w_slave_chk i_chk (
    .clk    (clk),
    .rst    (rst),
    .wr_stb (wr.stb),
    .wr_fn  (wr.fn),
    .wr_dat (wr.dat),
    .st     (st),
    .pull   (bus_dat_low_o),
    .rd_act (rd_act)
);

// File: tb/test_ctl3w_slave.sv
module test_ctl3w_slave;
    import ctl3w_pkg::*;

    localparam int BH = 6;
    localparam int NV = 19;
    // {address, function byte, observed output, expected value}
    localparam logic [27:0] VEC [NV] = '{
        28'h4001001, 28'h4003003, 28'h4002003, 28'h4000000,
        28'h4103103, 28'h4102102, 28'h4200200, 28'h420D20C,
        28'h42F9209, 28'h430B30B, 28'h4414414, 28'h442A428,
        28'h44C5405, 28'h453F528, 28'h4500500, 28'h4604601,
        28'h4606602, 28'h4602602, 28'h4605600
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_clk = 1'b1, m_id = 1'b1, m_dat = 1'b1;
    logic [1:0] stat_n = 2'b11;
    logic dat_w;
    logic pull, src, mute, loud, wide;
    logic [3:0] bass, treble;
    logic [5:0] vol_l, vol_r;
    logic [1:0] mode;
    int errs = 0, checks = 0;
    logic [7:0] rb;

    always #4 clk = ~clk;
    assign dat_w = m_dat & ~pull;

    ctl3w_slave #(.ID_MIN_CYC(8)) i_ctl3w_slave (
        .clk(clk), .rst(rst), .bus_clk_i(m_clk), .bus_id_i(m_id),
        .bus_dat_i(dat_w), .stat_n_i(stat_n), .bus_dat_low_o(pull),
        .src_o(src), .mute_o(mute), .loud_o(loud), .wide_o(wide),
        .bass_o(bass), .treble_o(treble), .vol_l_o(vol_l), .vol_r_o(vol_r),
        .mode_o(mode)
    );

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        m_clk = 1'b0; m_dat = b; wt(BH);
        m_clk = 1'b1; wt(BH);
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic addr_ph(input logic [7:0] a, input int extra);
        m_clk = 1'b0; wt(BH);
        m_id = 1'b0; wt(BH);
        for (int i = 0; i < extra; i++) send_bit(1'b1);
        send_byte(a);
        m_dat = 1'b1; m_id = 1'b1; wt(BH);
    endtask

    task automatic end_pulse(input int w);
        m_dat = 1'b1; m_id = 1'b0; wt(w);
        m_id = 1'b1; wt(12);
    endtask

    task automatic xfer(input logic [7:0] a, input logic [7:0] d);
        addr_ph(a, 0);
        send_byte(d);
        end_pulse(20);
    endtask

    task automatic rd(input logic [7:0] a, input logic [1:0] later, output logic [7:0] r);
        addr_ph(a, 0);
        stat_n = later;
        for (int i = 7; i >= 0; i--) begin
            m_clk = 1'b0; m_dat = 1'b1; wt(BH);
            m_clk = 1'b1; wt(BH / 2);
            r[i] = dat_w;
            wt(BH - BH / 2);
        end
        end_pulse(20);
    endtask

    function automatic logic [7:0] obs(input logic [3:0] sel);
        case (sel)
            4'd0: return {6'd0, mute, src};
            4'd1: return {6'd0, wide, loud};
            4'd2: return {4'd0, bass};
            4'd3: return {4'd0, treble};
            4'd4: return {2'd0, vol_l};
            4'd5: return {2'd0, vol_r};
            default: return {6'd0, mode};
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] sel);
        case (sel)
            4'd0: return "R1/R4 source";
            4'd1: return "R1/R5 loudness";
            4'd2, 4'd3: return "R1/R6 tone";
            4'd4, 4'd5: return "R1/R7 volume";
            default: return "R1/R8 mode";
        endcase
    endfunction

    task automatic chk_reset_state();
        chk("R10 vol_l", vol_l, 40);
        chk("R10 vol_r", vol_r, 40);
        chk("R10 bass", bass, 6);
        chk("R10 treble", treble, 6);
        chk("R10 mute/src", {mute, src}, 2'b10);
        chk("R10 loud/wide", {loud, wide}, 0);
        chk("R10 mode", mode, 0);
        chk("R10 pull", pull, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog R2: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        wt(5);
        chk_reset_state();
        rst = 1'b0;
        wt(10);

        for (int i = 0; i < NV; i++) begin
            xfer(VEC[i][27:20], VEC[i][19:12]);
            chk(req_of(VEC[i][11:8]), obs(VEC[i][11:8]), VEC[i][7:0]);
        end
        // now: vol_l 5, vol_r 0, src 0, mute 0

        // R2: no commit pulse, then a too short pulse
        addr_ph(8'h44, 0);
        send_byte(8'h00);
        m_dat = 1'b1; wt(30);
        chk("R2 no pulse", vol_l, 5);
        end_pulse(3);
        chk("R2 short pulse", vol_l, 5);

        // R3: foreign addresses
        xfer(8'h4C, 8'h00);
        chk("R3 addr 4C", vol_l, 5);
        xfer(8'hC4, 8'h00);
        chk("R3 addr C4", vol_l, 5);
        xfer(8'h04, 8'h00);
        chk("R3 addr 04", vol_l, 5);
        stat_n = 2'b00;
        rd(8'h4F, 2'b00, rb);
        chk("R3 no drive on 4F", rb, 8'hFF);

        // R1: overlong address and data phases
        addr_ph(8'h45, 4);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        send_byte(8'h11);
        end_pulse(20);
        chk("R1 long phases", vol_r, 17);

        // R9: status read-back
        stat_n = 2'b10;
        rd(8'h47, 2'b10, rb);
        chk("R9 read 10", rb, 8'hFE);
        stat_n = 2'b01;
        rd(8'h47, 2'b01, rb);
        chk("R9 read 01", rb, 8'hFD);
        stat_n = 2'b10;
        rd(8'h47, 2'b01, rb);
        chk("R9 latched at address", rb, 8'hFE);
        chk("R9 read leaves volume", vol_l, 5);
        chk("R9 read leaves source", {mute, src}, 2'b00);
        chk("R9 released after read", pull, 0);

        // R10: reset again
        @(negedge clk); rst = 1'b1;
        wt(3);
        chk_reset_state();
        rst = 1'b0;
        wt(5);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule